// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Erase Suspend

This block carries out program and erase operations on a flash array whose address space is split into blocks of unequal size. A command interpreter hands it one request at a time: a byte program or a block erase, with an 18-bit target address and a data byte. The sequencer works out which block the address falls in and checks two qualified inputs. One says the program supply is valid. The other says the high-voltage unlock on the reset pin is present, and only the boot block needs it. It then either aborts the request with error bits set or times the operation with a cycle counter. When the counter runs out, it issues a one-cycle strobe to the array.

An erase in progress can be suspended and later resumed, and it keeps the cycles it has left across the suspension. While an erase is suspended, the read path may use every block except the one being erased. The status byte gives the ready and suspend flags, which come from the controller state, and three sticky error flags that only a clear request or reset removes.

Top module: `flash_pe_seq`

## Requirements
- R1: Block decode (code on `arr_blk`): 0 for 0x00000–0x1FFFF, 1 for 0x20000–0x37FFF, 2 for 0x38000–0x39FFF, 3 for 0x3A000–0x3BFFF, 4 (boot) for 0x3C000–0x3FFFF.
- R2: An accepted program keeps status bit 7 at 0 for exactly PROG_CYC cycles after the accepting edge. In the cycle bit 7 returns to 1, `arr_prog_stb` is high for one cycle with the latched address and data.
- R3: An accepted erase keeps bit 7 at 0 for exactly ERASE_CYC cycles, and at the end pulses `arr_erase_stb` for one cycle with the target's block code on `arr_blk`.
- R4: A request made while `vpp_ok` is low is not started. Bit 3 is set together with bit 4 (program) or bit 5 (erase), bit 7 stays 1 and no strobe occurs.
- R5: A request aimed at block 4 while `boot_unlock` is low is not started and sets only bit 4 (program) or bit 5 (erase). With `boot_unlock` high it completes normally.
- R6: Bits 5..3 stay set until a `clear_req` cycle, which returns them to 0. Bits 2..0 always read 0. Status layout: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 supply error.
- R7: `suspend_req` during an erase gives one pending cycle with status 0x00 (bit 7 = 0), then the suspended state with bits 7 and 6 set. The remaining erase count is held, so the run cycles before and after the suspension add up to ERASE_CYC.
- R8: `resume_req` in the suspended state clears bits 7 and 6 on the next cycle and continues the erase. A resume outside suspension and a suspend outside an erase have no effect.
- R9: If `vpp_ok` drops while a suspension is pending or in effect, the erase is abandoned: bit 3 is set, bit 6 clears, bit 7 reads 1, and no erase strobe follows.
- R10: If `vpp_ok` drops while an operation runs, it aborts without a strobe and sets bit 3 together with bit 4 or bit 5 for that operation.
- R11: Asserting `rst_n` low immediately forces status to 0x80 and both strobes low, from any state.
- R12: `rd_allow` is 1 when idle and 0 while busy. While suspended it is 1 only if `rd_addr` decodes to a block other than the one being erased.
- R13: A request presented while an operation is running, pending suspension or suspended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle request for an operation |
| cmd_erase | input | 1 | 1 = block erase, 0 = byte program |
| cmd_addr | input | ADDR_W | Target address |
| cmd_data | input | DATA_W | Data byte for a program |
| suspend_req | input | 1 | Request erase suspension |
| resume_req | input | 1 | Request erase resumption |
| clear_req | input | 1 | Clear status bits 5..3 |
| vpp_ok | input | 1 | Program supply qualified as valid |
| boot_unlock | input | 1 | High-voltage unlock for the boot block |
| rd_addr | input | ADDR_W | Address the read path wants to use |
| rd_allow | output | 1 | Read of rd_addr is permitted now |
| status | output | 8 | Status byte |
| arr_prog_stb | output | 1 | One-cycle program strobe to the array |
| arr_erase_stb | output | 1 | One-cycle erase strobe to the array |
| arr_addr | output | ADDR_W | Latched target address |
| arr_data | output | DATA_W | Latched program data |
| arr_blk | output | 3 | Block code of the latched target |

## Verification
The bench builds the sequencer with PROG_CYC = 6 and ERASE_CYC = 40. With these values every decode boundary can be erased in turn within a short run. An erase is also long enough to suspend after eleven cycles and then count the 29 cycles left after resume, which shows that the count is held. Aborts from both qualifying inputs, a supply drop while running and while suspended, and reset during an erase each take only a handful of cycles to reach.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [2:0] {
    BLK_MAIN_LO = 3'd0,
    BLK_MAIN_HI = 3'd1,
    BLK_PARM_A  = 3'd2,
    BLK_PARM_B  = 3'd3,
    BLK_BOOT    = 3'd4
  } blk_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_ERASE = 3'd2,
    ST_SPEND = 3'd3,
    ST_SUSP  = 3'd4
  } seq_st_e;

endpackage

// File: rtl/pes_blkdec.sv
module pes_blkdec
  import pes_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] MAIN_HI_BASE = 'h20000,
  parameter logic [ADDR_W-1:0] PARM_A_BASE  = 'h38000,
  parameter logic [ADDR_W-1:0] PARM_B_BASE  = 'h3A000,
  parameter logic [ADDR_W-1:0] BOOT_BASE    = 'h3C000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output blk_e              blk_o
);

  always_comb begin
    if (addr_i >= BOOT_BASE)         blk_o = BLK_BOOT;
    else if (addr_i >= PARM_B_BASE)  blk_o = BLK_PARM_B;
    else if (addr_i >= PARM_A_BASE)  blk_o = BLK_PARM_A;
    else if (addr_i >= MAIN_HI_BASE) blk_o = BLK_MAIN_HI;
    else                             blk_o = BLK_MAIN_LO;
  end

endmodule

// File: rtl/pes_timer.sv
module pes_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                   cnt_d = load_val_i;
    else if (run_i && cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CNT_W'(1));
  assign cnt_o  = cnt_q;

  // R2
  run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q != '0));

endmodule

// File: rtl/pes_status.sv
module pes_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_vpp_i,
  input  logic       set_prog_i,
  input  logic       set_erase_i,
  input  logic       clr_i,
  input  logic       ready_i,
  input  logic       susp_i,
  output logic [7:0] status_o
);

  logic [2:0] err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (clr_i) err_d = '0;
    err_d = err_d | {set_erase_i, set_prog_i, set_vpp_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assign status_o = {ready_i, susp_i, err_q, 3'b000};

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R6
  clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_vpp_i && !set_prog_i && !set_erase_i) |=> (status_o[5:3] == 3'b000));

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import pes_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_erase,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              clear_req,
  input  logic              vpp_ok,
  input  logic              boot_unlock,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_allow,
  output logic [7:0]        status,
  output logic              arr_prog_stb,
  output logic              arr_erase_stb,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic [2:0]        arr_blk
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int N_DEC   = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1] & rst_n;

  // block decoders: index 0 for the request, 1 for the read path
  logic [ADDR_W-1:0] dec_addr [N_DEC];
  blk_e              dec_blk  [N_DEC];

  assign dec_addr[0] = cmd_addr;
  assign dec_addr[1] = rd_addr;

  for (genvar gi = 0; gi < N_DEC; gi++) begin : g_dec
    pes_blkdec #(.ADDR_W(ADDR_W)) u_dec (
      .addr_i (dec_addr[gi]),
      .blk_o  (dec_blk[gi])
    );
  end

  // state and target registers
  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] tgt_addr_q;
  logic [DATA_W-1:0] tgt_data_q;
  blk_e              tgt_blk_q;
  logic              lat_en;
  logic              prog_stb_q, prog_stb_d;
  logic              erase_stb_q, erase_stb_d;

  logic              tm_load, tm_run, tm_last;
  logic [CNT_W-1:0]  tm_load_val, tm_cnt;
  logic              set_vpp, set_prog, set_erase;

  always_comb begin
    st_d        = st_q;
    lat_en      = 1'b0;
    tm_load     = 1'b0;
    tm_load_val = CNT_W'(PROG_CYC);
    tm_run      = 1'b0;
    set_vpp     = 1'b0;
    set_prog    = 1'b0;
    set_erase   = 1'b0;
    prog_stb_d  = 1'b0;
    erase_stb_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (!vpp_ok) begin
            set_vpp   = 1'b1;
            set_prog  = !cmd_erase;
            set_erase = cmd_erase;
          end else if (dec_blk[0] == BLK_BOOT && !boot_unlock) begin
            set_prog  = !cmd_erase;
            set_erase = cmd_erase;
          end else begin
            lat_en      = 1'b1;
            tm_load     = 1'b1;
            tm_load_val = cmd_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
            st_d        = cmd_erase ? ST_ERASE : ST_PROG;
          end
        end
      end
      ST_PROG: begin
        tm_run = 1'b1;
        if (!vpp_ok) begin
          set_vpp  = 1'b1;
          set_prog = 1'b1;
          st_d     = ST_IDLE;
        end else if (tm_last) begin
          prog_stb_d = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      ST_ERASE: begin
        tm_run = 1'b1;
        if (!vpp_ok) begin
          set_vpp   = 1'b1;
          set_erase = 1'b1;
          st_d      = ST_IDLE;
        end else if (tm_last) begin
          erase_stb_d = 1'b1;
          st_d        = ST_IDLE;
        end else if (suspend_req) begin
          st_d = ST_SPEND;
        end
      end
      ST_SPEND: begin
        if (!vpp_ok) begin
          set_vpp = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          st_d = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (!vpp_ok) begin
          set_vpp = 1'b1;
          st_d    = ST_IDLE;
        end else if (resume_req) begin
          st_d = ST_ERASE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q        <= ST_IDLE;
      prog_stb_q  <= 1'b0;
      erase_stb_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      prog_stb_q  <= prog_stb_d;
      erase_stb_q <= erase_stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tgt_addr_q <= '0;
      tgt_data_q <= '0;
      tgt_blk_q  <= BLK_MAIN_LO;
    end else if (lat_en) begin
      tgt_addr_q <= cmd_addr;
      tgt_data_q <= cmd_data;
      tgt_blk_q  <= dec_blk[0];
    end
  end

  pes_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_i     (tm_load),
    .load_val_i (tm_load_val),
    .run_i      (tm_run),
    .last_o     (tm_last),
    .cnt_o      (tm_cnt)
  );

  logic st_ready, st_susp;
  assign st_ready = (st_q == ST_IDLE) || (st_q == ST_SUSP);
  assign st_susp  = (st_q == ST_SUSP);

  pes_status u_status (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .set_vpp_i   (set_vpp),
    .set_prog_i  (set_prog),
    .set_erase_i (set_erase),
    .clr_i       (clear_req),
    .ready_i     (st_ready),
    .susp_i      (st_susp),
    .status_o    (status)
  );

  assign rd_allow      = (st_q == ST_IDLE) || (st_susp && (dec_blk[1] != tgt_blk_q));
  assign arr_prog_stb  = prog_stb_q;
  assign arr_erase_stb = erase_stb_q;
  assign arr_addr      = tgt_addr_q;
  assign arr_data      = tgt_data_q;
  assign arr_blk       = tgt_blk_q;

  // R2 R3
  stb_at_ready_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (arr_prog_stb || arr_erase_stb) |-> (status[7] && !$past(status[7])));

  // R2 R3
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({arr_prog_stb, arr_erase_stb}));

  // R4 R10
  start_vpp_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((st_q == ST_PROG || st_q == ST_ERASE) && $past(st_q) == ST_IDLE) |-> $past(vpp_ok));

  // R5
  start_boot_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((st_q == ST_PROG || st_q == ST_ERASE) && $past(st_q) == ST_IDLE && tgt_blk_q == BLK_BOOT)
      |-> $past(boot_unlock));

  // R7
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_SUSP) |-> ($past(st_q) == ST_SPEND || $past(st_q) == ST_SUSP));

  // R7
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_SUSP && $past(st_q) == ST_SUSP) |-> $stable(tm_cnt));

  // R12
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_allow |-> status[7]);

endmodule

// File: tb/sim_flash_pe_seq.sv
`timescale 1ns/1ps
module sim_flash_pe_seq;

  localparam int AW = 18;
  localparam int DW = 8;
  localparam int PCYC = 6;
  localparam int ECYC = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_erase, suspend_req, resume_req, clear_req;
  logic          vpp_ok, boot_unlock;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [DW-1:0] cmd_data;
  logic          rd_allow, arr_prog_stb, arr_erase_stb;
  logic [7:0]    status;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [2:0]    arr_blk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  flash_pe_seq #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_erase(cmd_erase),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .suspend_req(suspend_req),
    .resume_req(resume_req), .clear_req(clear_req), .vpp_ok(vpp_ok),
    .boot_unlock(boot_unlock), .rd_addr(rd_addr), .rd_allow(rd_allow),
    .status(status), .arr_prog_stb(arr_prog_stb), .arr_erase_stb(arr_erase_stb),
    .arr_addr(arr_addr), .arr_data(arr_data), .arr_blk(arr_blk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic erase, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_erase = erase; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear_req = 1'b1;
    @(negedge clk); clear_req = 1'b0;
  endtask

  // counts busy samples until ready; returns count and strobes seen while busy
  task automatic wait_ready(output int lows, output int early_stb);
    lows = 0; early_stb = 0;
    while (!status[7] && lows < 1000) begin
      lows++;
      if (arr_prog_stb || arr_erase_stb) early_stb++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    rd_addr = '0;
    chk("R11 reset status", status, 8'h80);
    chk("R11 reset strobes", {arr_prog_stb, arr_erase_stb}, 2'b00);
    chk("R12 idle rd_allow", rd_allow, 1'b1);
    chk("R6 low bits zero", status[2:0], 3'b000);
  endtask

  task automatic t_program();
    int lows, es;
    issue(1'b0, 18'h01234, 8'hA5);
    chk("R12 busy rd_allow", rd_allow, 1'b0);
    wait_ready(lows, es);
    chk("R2 program busy cycles", lows, PCYC);
    chk("R2 prog strobe at ready", arr_prog_stb, 1'b1);
    chk("R2 no erase strobe", arr_erase_stb, 1'b0);
    chk("R2 strobe addr", arr_addr, 18'h01234);
    chk("R2 strobe data", arr_data, 8'hA5);
    @(negedge clk);
    chk("R2 strobe one cycle", arr_prog_stb, 1'b0);
    chk("R2 status after program", status, 8'h80);
  endtask

  task automatic erase_blk(input logic [AW-1:0] a, input logic [2:0] exp_blk, input string tag);
    int lows, es;
    issue(1'b1, a, 8'h00);
    wait_ready(lows, es);
    chk({tag, " erase cycles R3"}, lows, ECYC);
    chk({tag, " erase strobe R3"}, arr_erase_stb, 1'b1);
    chk({tag, " block code R1"}, arr_blk, exp_blk);
  endtask

  task automatic t_decode();
    erase_blk(18'h1FFFF, 3'd0, "R1 top of main lo");
    erase_blk(18'h20000, 3'd1, "R1 base of main hi");
    erase_blk(18'h37FFF, 3'd1, "R1 top of main hi");
    erase_blk(18'h38000, 3'd2, "R1 base param a");
    erase_blk(18'h39FFF, 3'd2, "R1 top param a");
    erase_blk(18'h3A000, 3'd3, "R1 base param b");
    boot_unlock = 1'b1;
    erase_blk(18'h3C000, 3'd4, "R5 boot unlocked");
    boot_unlock = 1'b0;
    @(negedge clk);
    chk("R3 status after erases", status, 8'h80);
  endtask

  task automatic t_boot_locked();
    int stb = 0;
    issue(1'b0, 18'h3C010, 8'h11);
    chk("R5 boot locked status", status, 8'h90);
    repeat (PCYC + 3) begin
      if (arr_prog_stb || !status[7]) stb++;
      @(negedge clk);
    end
    chk("R5 boot locked no start", stb, 0);
    chk("R6 error sticky", status, 8'h90);
    do_clear();
    chk("R6 clear", status, 8'h80);
  endtask

  task automatic t_vpp_low();
    vpp_ok = 1'b0;
    issue(1'b1, 18'h00100, 8'h00);
    chk("R4 erase vpp low", status, 8'hA8);
    do_clear();
    issue(1'b0, 18'h00100, 8'h22);
    chk("R4 program vpp low", status, 8'h98);
    repeat (PCYC + 2) @(negedge clk);
    chk("R4 no strobe", {arr_prog_stb, arr_erase_stb}, 2'b00);
    vpp_ok = 1'b1;
    do_clear();
    chk("R6 clear after vpp", status, 8'h80);
  endtask

  // brings an erase of param b to the suspended state after 11 run cycles
  task automatic go_suspended();
    issue(1'b1, 18'h3A500, 8'h00);
    repeat (10) @(negedge clk);
    suspend_req = 1'b1;
    @(negedge clk);
    suspend_req = 1'b0;
    chk("R7 pending status", status, 8'h00);
    @(negedge clk);
    chk("R7 suspended status", status, 8'hC0);
  endtask

  task automatic t_suspend();
    int lows, es, stb;
    go_suspended();
    rd_addr = 18'h3A7FF;
    #1 chk("R12 read erased block", rd_allow, 1'b0);
    rd_addr = 18'h39000;
    #1 chk("R12 read other param", rd_allow, 1'b1);
    rd_addr = 18'h00010;
    #1 chk("R12 read main", rd_allow, 1'b1);
    stb = 0;
    repeat (ECYC) begin
      if (arr_erase_stb || status != 8'hC0) stb++;
      @(negedge clk);
    end
    chk("R7 suspension held", stb, 0);
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
    chk("R8 resume status", status, 8'h00);
    wait_ready(lows, es);
    chk("R7 remaining cycles", lows, ECYC - 11);
    chk("R7 erase strobe after resume", arr_erase_stb, 1'b1);
    chk("R7 block kept", arr_blk, 3'd3);
    rd_addr = '0;
  endtask

  task automatic t_ignored();
    int lows, es, stb;
    resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
    chk("R8 resume when idle", status, 8'h80);
    issue(1'b0, 18'h00200, 8'h5A);
    suspend_req = 1'b1;
    cmd_valid = 1'b1; cmd_erase = 1'b1; cmd_addr = 18'h00300;
    @(negedge clk);
    suspend_req = 1'b0; cmd_valid = 1'b0;
    wait_ready(lows, es);
    chk("R8 suspend during program ignored", lows, PCYC - 1);
    chk("R8 program strobe", arr_prog_stb, 1'b1);
    chk("R13 busy request kept addr", arr_addr, 18'h00200);
    stb = 0;
    repeat (ECYC + 5) begin
      if (arr_erase_stb || !status[7]) stb++;
      @(negedge clk);
    end
    chk("R13 busy request ignored", stb, 0);
  endtask

  task automatic t_susp_vpp();
    int stb = 0;
    go_suspended();
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R9 abandon status", status, 8'h88);
    vpp_ok = 1'b1;
    repeat (ECYC + 5) begin
      if (arr_erase_stb || status != 8'h88) stb++;
      @(negedge clk);
    end
    chk("R9 no erase after abandon", stb, 0);
    do_clear();
  endtask

  task automatic t_run_vpp();
    int stb = 0;
    issue(1'b1, 18'h20010, 8'h00);
    repeat (5) @(negedge clk);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R10 erase abort status", status, 8'hA8);
    vpp_ok = 1'b1;
    repeat (ECYC) begin
      if (arr_erase_stb) stb++;
      @(negedge clk);
    end
    chk("R10 no strobe", stb, 0);
    do_clear();
    issue(1'b0, 18'h20010, 8'h33);
    @(negedge clk);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk("R10 program abort status", status, 8'h98);
    vpp_ok = 1'b1;
    do_clear();
  endtask

  task automatic t_reset_mid();
    int stb = 0;
    issue(1'b1, 18'h00400, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 reset mid erase", status, 8'h80);
    chk("R11 reset strobes low", {arr_prog_stb, arr_erase_stb}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (ECYC + 5) begin
      if (arr_erase_stb || status != 8'h80) stb++;
      @(negedge clk);
    end
    chk("R11 operation stopped", stb, 0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_erase = 1'b0; cmd_addr = '0; cmd_data = '0;
    suspend_req = 1'b0; resume_req = 1'b0; clear_req = 1'b0;
    vpp_ok = 1'b1; boot_unlock = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_program();
    t_decode();
    t_boot_locked();
    t_vpp_low();
    t_suspend();
    t_ignored();
    t_susp_vpp();
    t_run_vpp();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule